// File: doc/BRIEF.md
# Precise-Exception Completion Queue

This block keeps instructions in program order while the execution units finish them in any order. Each dispatched instruction gets the next slot of a six-entry circular queue and the slot index as its tag. Execution units later report completion against that tag, with an exception flag and a two-bit cause. Entries leave from the head strictly in order, at most one per cycle, and only once they are marked done.

When the head entry is done and carries an exception, the block takes it. In that cycle it presents the handler address, which is a selectable base plus a cause-dependent offset. On the same clock edge it empties the whole queue: the excepting entry and everything younger are discarded, and the tail pointer goes back to slot 0. It also records the faulting instruction address and the current machine status word in two save registers. A later return request copies the saved status back out as a one-cycle status write. Only the oldest entry can trap, so an older exception always wins over a younger one.

Stores wait in an external buffer. The block raises a per-slot release bit for a store when every older entry has finished cleanly, or when the store is itself at the head. At most four of the six entries may be integer-class instructions at once. The remaining capacity serves branch and condition-code instructions.

Top module: `prec_cq`

## Requirements
- R1: After reset the queue is empty: `disp_ready` is 1, `disp_tag` is 0, `retire_valid`, `exc_take`, `msr_wr_en` and every `st_ok` bit are 0, and `save_pc` and `save_status` are 0.
- R2: The queue holds at most 6 entries. With 6 held, `disp_ready` is 0 for every class until an entry retires.
- R3: Class code 0 on `disp_class` is integer (1 is branch, 2 is condition code). With 4 integer entries held, `disp_ready` is 0 for an integer request but stays 1 for a non-integer one while free slots remain. An integer request is accepted again in the cycle after an integer entry retires.
- R4: Accepted dispatches receive sequential slot tags 0,1,…,5 on `disp_tag`, wrapping from 5 back to 0.
- R5: `retire_valid` is 1 only while the head entry is done without exception, and `retire_pc` then gives its address. Younger done entries wait for the head. At most one entry retires per cycle.
- R6: `exc_take` is 1 in the cycle the head entry is done with an exception. `exc_vector` is then `vec_base` plus 0x1D00, 0x1C00, 0x1E00 or 0x1F00 for cause 0, 1, 2 or 3 respectively. A younger entry's exception never fires while an older entry is still queued.
- R7: In the cycle after `exc_take`, the queue is empty and the next dispatch gets tag 0. A finish report aimed at a flushed slot has no effect.
- R8: In the cycle after `exc_take`, `save_pc` holds the excepting instruction's address and `save_status` holds `status_in` as sampled in the take cycle.
- R9: In the cycle after `rfi_req`, `msr_wr_en` is 1 and `msr_wr_data` equals `save_status`. Otherwise `msr_wr_en` is 0.
- R10: `st_ok[t]` is 1 for a queued store in slot t only when every older entry is done without exception, or when slot t is the head. It is 0 otherwise.
- R11: While `exc_take` is 1, `disp_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_class | input | 2 | 0 integer, 1 branch, 2 condition code |
| disp_store | input | 1 | Dispatched instruction is a store |
| disp_pc | input | 32 | Address of the dispatched instruction |
| disp_ready | output | 1 | Dispatch accepted this cycle if requested |
| disp_tag | output | 3 | Slot given to the dispatched instruction |
| fin_valid | input | 1 | Finish report |
| fin_tag | input | 3 | Slot being finished |
| fin_exc | input | 1 | Finished instruction raised an exception |
| fin_cause | input | 2 | Exception cause code |
| retire_valid | output | 1 | Head entry retires this cycle |
| retire_pc | output | 32 | Address of the retiring entry |
| vec_base | input | 32 | Base added to the exception offset |
| status_in | input | 32 | Current machine status word |
| exc_take | output | 1 | Head exception taken, queue flushed at edge |
| exc_vector | output | 32 | Handler fetch address |
| save_pc | output | 32 | Saved resume address |
| save_status | output | 32 | Saved status word |
| rfi_req | input | 1 | Return-from-interrupt request |
| msr_wr_en | output | 1 | Status restore strobe |
| msr_wr_data | output | 32 | Status word to restore |
| st_ok | output | 6 | Per-slot store release permission |

## Verification
The first pattern fills the queue with four integer entries followed by a branch and a condition-code entry, then finishes them out of order. This separates the total limit from the per-class limit, and shows whether done younger entries wait behind the head and drain one per cycle. A second pattern places an excepting younger entry behind an excepting older store. It tells oldest-first priority apart from first-reported priority, and shows the store release bit rising only after the older entry completes cleanly. The remaining patterns sweep the other cause codes under a non-zero base to separate the offsets, send a finish report to a flushed slot, and place a store at the head before it is done, as well as behind a faulting entry.

// File: rtl/cq_pkg.sv
package cq_pkg;

   typedef enum logic [1:0] {
      CLS_INT = 2'd0,
      CLS_BR  = 2'd1,
      CLS_CC  = 2'd2
   } cq_class_e;

   localparam logic [15:0] GEN_OFFSET = 16'h0700;

   // Handler offset for the debug cause codes.
   function automatic logic [15:0] dbg_offset(input logic [1:0] code);
      case (code)
         2'd0:    return 16'h1D00;
         2'd1:    return 16'h1C00;
         2'd2:    return 16'h1E00;
         default: return 16'h1F00;
      endcase
   endfunction

endpackage

// File: rtl/cq_occupancy.sv
module cq_occupancy #(
   parameter int DEPTH   = 6,
   parameter int INT_MAX = 4,
   parameter int CNTW    = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic            push_int,
   input  logic            pop,
   input  logic            pop_int,
   input  logic            flush,
   output logic [CNTW-1:0] count,
   output logic [CNTW-1:0] int_count,
   output logic            full,
   output logic            int_full
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count     <= '0;
         int_count <= '0;
      end else if (flush) begin
         count     <= '0;
         int_count <= '0;
      end else begin
         count     <= count + CNTW'(push) - CNTW'(pop);
         int_count <= int_count + CNTW'(push_int) - CNTW'(pop_int);
      end
   end

   assign full     = (count == CNTW'(DEPTH));
   assign int_full = (int_count == CNTW'(INT_MAX));

endmodule

// File: rtl/cq_vec_map.sv
module cq_vec_map #(
   parameter int AW = 32,
   parameter int CW = 2
) (
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] cause,
   output logic [AW-1:0] vector
);

   logic [15:0] off;

   if (AW < 16) begin : g_bad_aw
      $error("cq_vec_map: AW must be at least 16");
   end
   if (CW < 2) begin : g_bad_cw
      $error("cq_vec_map: CW must be at least 2");
   end

   generate
      if (CW == 2) begin : g_exact
         always_comb off = cq_pkg::dbg_offset(cause);
      end else begin : g_wide
         always_comb begin
            if (cause[CW-1:2] != '0) off = cq_pkg::GEN_OFFSET;
            else                     off = cq_pkg::dbg_offset(cause[1:0]);
         end
      end
   endgenerate

   assign vector = base + AW'(off);

endmodule

// File: rtl/cq_store_gate.sv
module cq_store_gate #(
   parameter int DEPTH = 6,
   parameter int IDXW  = 3
) (
   input  logic [IDXW-1:0]  head,
   input  logic [DEPTH-1:0] valid,
   input  logic [DEPTH-1:0] done,
   input  logic [DEPTH-1:0] exc,
   input  logic [DEPTH-1:0] store,
   output logic [DEPTH-1:0] ok
);

   always_comb begin
      logic clean;
      int   idx;
      ok    = '0;
      clean = 1'b1;
      for (int k = 0; k < DEPTH; k++) begin
         idx = int'(head) + k;
         if (idx >= DEPTH) idx = idx - DEPTH;
         if (valid[IDXW'(idx)] && store[IDXW'(idx)] && (k == 0 || clean))
            ok[IDXW'(idx)] = 1'b1;
         clean = clean & (~valid[IDXW'(idx)] |
                          (done[IDXW'(idx)] & ~exc[IDXW'(idx)]));
      end
   end

endmodule

// File: rtl/prec_cq.sv
module prec_cq #(
   parameter int DEPTH   = 6,
   parameter int INT_MAX = 4,
   parameter int AW      = 32,
   parameter int SW      = 32,
   parameter int CW      = 2,
   localparam int IDXW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNTW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             disp_valid,
   input  logic [1:0]       disp_class,
   input  logic             disp_store,
   input  logic [AW-1:0]    disp_pc,
   output logic             disp_ready,
   output logic [IDXW-1:0]  disp_tag,
   input  logic             fin_valid,
   input  logic [IDXW-1:0]  fin_tag,
   input  logic             fin_exc,
   input  logic [CW-1:0]    fin_cause,
   output logic             retire_valid,
   output logic [AW-1:0]    retire_pc,
   input  logic [AW-1:0]    vec_base,
   input  logic [SW-1:0]    status_in,
   output logic             exc_take,
   output logic [AW-1:0]    exc_vector,
   output logic [AW-1:0]    save_pc,
   output logic [SW-1:0]    save_status,
   input  logic             rfi_req,
   output logic             msr_wr_en,
   output logic [SW-1:0]    msr_wr_data,
   output logic [DEPTH-1:0] st_ok
);

   import cq_pkg::*;

   if (DEPTH < 2) begin : g_bad_depth
      $error("prec_cq: DEPTH must be at least 2");
   end
   if (INT_MAX < 1 || INT_MAX > DEPTH) begin : g_bad_int
      $error("prec_cq: INT_MAX must lie in 1..DEPTH");
   end

   // Pointers and per-slot state views
   logic [IDXW-1:0]  head_q, tail_q;
   logic [DEPTH-1:0] v_valid, v_done, v_exc, v_store, v_int;
   logic [CW-1:0]    cause_arr [DEPTH];
   logic [AW-1:0]    pc_arr    [DEPTH];

   logic             do_push, do_pop, do_take, disp_is_int, pop_is_int;
   logic [CNTW-1:0]  occ_count, occ_int;
   logic             occ_full, occ_int_full;

   function automatic logic [IDXW-1:0] ptr_next(input logic [IDXW-1:0] p);
      return (p == IDXW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign disp_is_int = (disp_class == CLS_INT);
   assign do_take     = v_valid[head_q] & v_done[head_q] & v_exc[head_q];
   assign do_pop      = v_valid[head_q] & v_done[head_q] & ~v_exc[head_q];
   assign pop_is_int  = do_pop & v_int[head_q];
   assign disp_ready  = ~occ_full & ~(disp_is_int & occ_int_full) & ~do_take;
   assign do_push     = disp_valid & disp_ready;
   assign disp_tag    = tail_q;

   // Entry storage, one slot per generate iteration
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic          s_valid, s_done, s_exc, s_store, s_int;
      logic [CW-1:0] s_cause;
      logic [AW-1:0] s_pc;
      logic          hit_push, hit_pop, hit_fin;

      assign hit_push = do_push && (tail_q == IDXW'(i));
      assign hit_pop  = do_pop && (head_q == IDXW'(i));
      assign hit_fin  = fin_valid && (fin_tag == IDXW'(i)) && s_valid;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_valid <= 1'b0;
            s_done  <= 1'b0;
            s_exc   <= 1'b0;
            s_store <= 1'b0;
            s_int   <= 1'b0;
            s_cause <= '0;
            s_pc    <= '0;
         end else if (do_take) begin
            s_valid <= 1'b0;
            s_done  <= 1'b0;
            s_exc   <= 1'b0;
         end else if (hit_push) begin
            s_valid <= 1'b1;
            s_done  <= 1'b0;
            s_exc   <= 1'b0;
            s_cause <= '0;
            s_store <= disp_store;
            s_int   <= disp_is_int;
            s_pc    <= disp_pc;
         end else if (hit_pop) begin
            s_valid <= 1'b0;
         end else if (hit_fin) begin
            s_done  <= 1'b1;
            s_exc   <= fin_exc;
            s_cause <= fin_cause;
         end
      end

      assign v_valid[i]   = s_valid;
      assign v_done[i]    = s_done;
      assign v_exc[i]     = s_exc;
      assign v_store[i]   = s_store;
      assign v_int[i]     = s_int;
      assign cause_arr[i] = s_cause;
      assign pc_arr[i]    = s_pc;
   end

   // Head and tail pointers; a taken exception rewinds both
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else if (do_take) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         if (do_pop)  head_q <= ptr_next(head_q);
         if (do_push) tail_q <= ptr_next(tail_q);
      end
   end

   cq_occupancy #(
      .DEPTH(DEPTH), .INT_MAX(INT_MAX), .CNTW(CNTW)
   ) u_occ (
      .clk(clk), .rst_n(rst_n),
      .push(do_push), .push_int(do_push & disp_is_int),
      .pop(do_pop), .pop_int(pop_is_int),
      .flush(do_take),
      .count(occ_count), .int_count(occ_int),
      .full(occ_full), .int_full(occ_int_full)
   );

   cq_vec_map #(.AW(AW), .CW(CW)) u_vec (
      .base(vec_base), .cause(cause_arr[head_q]), .vector(exc_vector)
   );

   cq_store_gate #(.DEPTH(DEPTH), .IDXW(IDXW)) u_stg (
      .head(head_q), .valid(v_valid), .done(v_done), .exc(v_exc),
      .store(v_store), .ok(st_ok)
   );

   assign retire_valid = do_pop;
   assign retire_pc    = pc_arr[head_q];
   assign exc_take     = do_take;

   // Saved state and status restore
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         save_pc     <= '0;
         save_status <= '0;
         msr_wr_en   <= 1'b0;
         msr_wr_data <= '0;
      end else begin
         if (do_take) begin
            save_pc     <= pc_arr[head_q];
            save_status <= status_in;
         end
         msr_wr_en <= rfi_req;
         if (rfi_req) msr_wr_data <= save_status;
      end
   end

endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
   parameter int DEPTH   = 6,
   parameter int INT_MAX = 4,
   parameter int CNTW    = 3,
   parameter int SW      = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            disp_ready,
   input logic            exc_take,
   input logic            rfi_req,
   input logic            msr_wr_en,
   input logic [SW-1:0]   msr_wr_data,
   input logic [SW-1:0]   save_status,
   input logic [SW-1:0]   status_in,
   input logic [CNTW-1:0] count,
   input logic [CNTW-1:0] int_count
);

   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNTW'(DEPTH));

   p_int_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int_count <= CNTW'(INT_MAX));

   p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take |=> (count == '0 && int_count == '0));

   p_save_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take |=> (save_status == $past(status_in)));

   p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rfi_req |=> (msr_wr_en && msr_wr_data == $past(save_status)));

   p_restore_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rfi_req |=> !msr_wr_en);

   p_block_disp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take |-> !disp_ready);

endmodule

bind prec_cq cq_checker #(
   .DEPTH(DEPTH), .INT_MAX(INT_MAX), .CNTW(CNTW), .SW(SW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .disp_ready(disp_ready), .exc_take(exc_take),
   .rfi_req(rfi_req), .msr_wr_en(msr_wr_en), .msr_wr_data(msr_wr_data),
   .save_status(save_status), .status_in(status_in),
   .count(occ_count), .int_count(occ_int)
);

// File: tb/prec_cq_bench.sv
module prec_cq_bench;

   localparam int DEPTH = 6;
   localparam int AW    = 32;
   localparam int SW    = 32;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst_n;
   logic             disp_valid, disp_store, fin_valid, fin_exc, rfi_req;
   logic [1:0]       disp_class, fin_cause;
   logic [AW-1:0]    disp_pc, vec_base;
   logic [SW-1:0]    status_in;
   logic [2:0]       fin_tag;
   logic             disp_ready, retire_valid, exc_take, msr_wr_en;
   logic [2:0]       disp_tag;
   logic [AW-1:0]    retire_pc, exc_vector, save_pc;
   logic [SW-1:0]    save_status, msr_wr_data;
   logic [DEPTH-1:0] st_ok;

   prec_cq u_prec_cq (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_class(disp_class), .disp_store(disp_store),
      .disp_pc(disp_pc), .disp_ready(disp_ready), .disp_tag(disp_tag),
      .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_exc(fin_exc),
      .fin_cause(fin_cause), .retire_valid(retire_valid), .retire_pc(retire_pc),
      .vec_base(vec_base), .status_in(status_in), .exc_take(exc_take),
      .exc_vector(exc_vector), .save_pc(save_pc), .save_status(save_status),
      .rfi_req(rfi_req), .msr_wr_en(msr_wr_en), .msr_wr_data(msr_wr_data),
      .st_ok(st_ok)
   );

   int n_chk = 0;
   int n_err = 0;

   // Snapshot of outputs taken 1 ns after the inputs settle
   logic             s_ready, s_ret, s_take, s_mwe;
   logic [2:0]       s_tag;
   logic [AW-1:0]    s_rpc, s_vec, s_spc;
   logic [SW-1:0]    s_sst, s_mwd;
   logic [DEPTH-1:0] s_stok;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_inputs();
      disp_valid = 1'b0; disp_class = 2'd1; disp_store = 1'b0; disp_pc = '0;
      fin_valid = 1'b0; fin_tag = '0; fin_exc = 1'b0; fin_cause = '0;
      rfi_req = 1'b0;
   endtask

   // Called at a falling edge with inputs already set.
   task automatic step();
      #1;
      s_ready = disp_ready; s_tag = disp_tag; s_ret = retire_valid;
      s_rpc = retire_pc; s_take = exc_take; s_vec = exc_vector;
      s_spc = save_pc; s_sst = save_status; s_mwe = msr_wr_en;
      s_mwd = msr_wr_data; s_stok = st_ok;
      @(negedge clk);
      clear_inputs();
   endtask

   task automatic set_disp(input logic [1:0] c, input logic st, input logic [31:0] pc);
      disp_valid = 1'b1; disp_class = c; disp_store = st; disp_pc = pc;
   endtask

   task automatic set_fin(input logic [2:0] t, input logic e, input logic [1:0] c);
      fin_valid = 1'b1; fin_tag = t; fin_exc = e; fin_cause = c;
   endtask

   function automatic logic [31:0] exp_vec(input logic [31:0] b, input logic [1:0] c);
      logic [31:0] o;
      case (c)
         2'd0: o = 32'h1D00;
         2'd1: o = 32'h1C00;
         2'd2: o = 32'h1E00;
         default: o = 32'h1F00;
      endcase
      return b + o;
   endfunction

   task automatic t_reset();
      disp_class = 2'd0;
      step();
      chk("R1", "ready", s_ready, 1);
      chk("R1", "tag", s_tag, 0);
      chk("R1", "retire", s_ret, 0);
      chk("R1", "take", s_take, 0);
      chk("R1", "st_ok", s_stok, 0);
      chk("R1", "save_pc", s_spc, 0);
      chk("R1", "save_status", s_sst, 0);
      chk("R1", "msr_wr_en", s_mwe, 0);
   endtask

   task automatic t_fill_and_order();
      for (int k = 0; k < 4; k++) begin
         set_disp(2'd0, 1'b0, 32'h100 + 32'(4 * k));
         step();
         chk("R4", "int tag", s_tag, 3'(k));
         chk("R2", "ready int", s_ready, 1);
      end
      set_disp(2'd0, 1'b0, 32'h1F0); step();
      chk("R3", "int blocked at limit", s_ready, 0);
      set_disp(2'd1, 1'b0, 32'h110); step();
      chk("R3", "branch accepted at int limit", s_ready, 1);
      chk("R4", "branch tag", s_tag, 4);
      set_disp(2'd2, 1'b0, 32'h114); step();
      chk("R4", "cc tag", s_tag, 5);
      set_disp(2'd1, 1'b0, 32'h1F4); step();
      chk("R2", "full blocks branch", s_ready, 0);
      set_fin(3'd2, 1'b0, 2'd0); step();
      chk("R5", "no retire before head done", s_ret, 0);
      step();
      chk("R5", "younger done waits", s_ret, 0);
      set_fin(3'd0, 1'b0, 2'd0); step();
      chk("R5", "head finishing this cycle", s_ret, 0);
      disp_class = 2'd0; step();
      chk("R5", "retire head", s_ret, 1);
      chk("R5", "retire pc", s_rpc, 32'h100);
      chk("R3", "int still blocked in retire cycle", s_ready, 0);
      disp_class = 2'd0; step();
      chk("R3", "int released after retire", s_ready, 1);
      chk("R5", "head 1 not done", s_ret, 0);
      set_fin(3'd1, 1'b0, 2'd0); step();
      chk("R5", "head 1 finishing", s_ret, 0);
      step();
      chk("R5", "retire pc 1", s_rpc, 32'h104);
      step();
      chk("R5", "retire pc 2 next cycle", s_rpc, 32'h108);
      chk("R5", "retire 2 valid", s_ret, 1);
      step();
      chk("R5", "head 3 not done", s_ret, 0);
      set_fin(3'd3, 1'b0, 2'd0); step();
      set_fin(3'd4, 1'b0, 2'd0); step();
      chk("R5", "retire pc 3", s_rpc, 32'h10C);
      set_fin(3'd5, 1'b0, 2'd0); step();
      chk("R5", "retire pc 4", s_rpc, 32'h110);
      step();
      chk("R5", "retire pc 5", s_rpc, 32'h114);
      step();
      chk("R5", "drained", s_ret, 0);
      chk("R4", "tag wrapped", s_tag, 0);
   endtask

   task automatic t_priority_and_flush();
      vec_base = 32'h0; status_in = 32'hABCD_0001;
      set_disp(2'd0, 1'b0, 32'h200); step();
      set_disp(2'd0, 1'b1, 32'h204); step();
      chk("R4", "store tag", s_tag, 1);
      set_disp(2'd1, 1'b0, 32'h208); step();
      chk("R10", "store held behind unfinished", s_stok[1], 0);
      set_fin(3'd2, 1'b1, 2'd3); step();
      step();
      chk("R6", "younger exception not taken", s_take, 0);
      set_fin(3'd0, 1'b0, 2'd0); step();
      chk("R10", "store held in finish cycle", s_stok[1], 0);
      step();
      chk("R10", "store released after older done", s_stok[1], 1);
      chk("R5", "retire older", s_rpc, 32'h200);
      set_fin(3'd1, 1'b1, 2'd1); step();
      chk("R6", "take waits for done", s_take, 0);
      set_disp(2'd1, 1'b0, 32'h2F0); step();
      chk("R6", "older exception taken", s_take, 1);
      chk("R6", "vector cause1", s_vec, exp_vec(32'h0, 2'd1));
      chk("R11", "dispatch blocked on take", s_ready, 0);
      chk("R5", "no retire on take", s_ret, 0);
      status_in = 32'h0;
      set_disp(2'd1, 1'b0, 32'h300); step();
      chk("R8", "save pc", s_spc, 32'h204);
      chk("R8", "save status", s_sst, 32'hABCD_0001);
      chk("R7", "flushed no take", s_take, 0);
      chk("R7", "flushed no retire", s_ret, 0);
      chk("R7", "tag reset", s_tag, 0);
      chk("R7", "ready after flush", s_ready, 1);
      set_fin(3'd1, 1'b1, 2'd2); step();
      step();
      chk("R7", "stale finish no take", s_take, 0);
      chk("R7", "stale finish no retire", s_ret, 0);
      set_fin(3'd0, 1'b0, 2'd0); step();
      step();
      chk("R5", "retire post-flush entry", s_rpc, 32'h300);
      step();
   endtask

   task automatic t_vectors();
      logic [1:0] cs [3] = '{2'd0, 2'd2, 2'd3};
      vec_base = 32'h0010_0000;
      for (int j = 0; j < 3; j++) begin
         logic [2:0] t;
         status_in = 32'h5500 + 32'(j);
         set_disp(2'd1, 1'b0, 32'h400 + 32'(j)); step();
         t = s_tag;
         set_fin(t, 1'b1, cs[j]); step();
         step();
         chk("R6", "take", s_take, 1);
         chk("R6", "vector", s_vec, exp_vec(32'h0010_0000, cs[j]));
         step();
         chk("R8", "save pc", s_spc, 32'h400 + 32'(j));
         chk("R8", "save status", s_sst, 32'h5500 + 32'(j));
      end
   endtask

   task automatic t_restore();
      rfi_req = 1'b1; step();
      chk("R9", "no write same cycle", s_mwe, 0);
      step();
      chk("R9", "write strobe", s_mwe, 1);
      chk("R9", "write data", s_mwd, 32'h5502);
      step();
      chk("R9", "single pulse", s_mwe, 0);
   endtask

   task automatic t_store_cases();
      set_disp(2'd0, 1'b0, 32'h500); step();
      chk("R7", "tag after flush", s_tag, 0);
      set_disp(2'd0, 1'b1, 32'h504); step();
      set_fin(3'd0, 1'b1, 2'd2); step();
      step();
      chk("R6", "take older", s_take, 1);
      chk("R10", "store behind fault held", s_stok[1], 0);
      set_disp(2'd1, 1'b1, 32'h600); step();
      chk("R7", "store gets slot 0", s_tag, 0);
      step();
      chk("R10", "store at head released", s_stok[0], 1);
      chk("R5", "store not done no retire", s_ret, 0);
      set_fin(3'd0, 1'b0, 2'd0); step();
      step();
      chk("R5", "store retires", s_rpc, 32'h600);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      clear_inputs();
      vec_base = '0; status_in = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill_and_order();
      t_priority_and_flush();
      t_vectors();
      t_restore();
      t_store_cases();
      summary();
      $finish;
   end

endmodule